// File: doc/BRIEF.md
# Transmit Data Frame Packetizer

This block builds the outgoing frames handed to a serial-storage link layer over a 32-bit framed interface whose valid, end-of-frame and ready lines are all active low. A command sequencer starts it in one of two ways. A command start sends a fixed number of command-frame words, which the sequencer holds on a flat input vector. A data start with a dword count turns the user transmit FIFO's contents into one or more data frames. Each data frame is a single header word followed by payload dwords. No data frame carries more than a set maximum of payload.

The FIFO returns read data one clock after the read strobe. The link may stall the output at any cycle. The block keeps at most two dwords in hand, one in the output register and one in a skid register, so nothing is lost when a stall arrives while a read is in flight. Reads pause while the link stalls or the FIFO reports empty. Reads stop once the requested count has been read.

The controlling state machine has five states:
- ST_IDLE: waiting for a start.
- ST_CMD: sending command words. It moves to ST_FLUSH once the last word is loaded.
- ST_HDR: loading a header word, then moving to ST_PAY.
- ST_PAY: moving payload. At the last dword of a frame it goes to ST_HDR if payload remains, and to ST_FLUSH if none remains.
- ST_FLUSH: waiting for the link to accept the final word, then returning to ST_IDLE.

Top module: `txpk_top`

## Requirements
- R1: After reset, busy is 0, tx_valid_n and tx_eof_n are 1 and fifo_rd_en is 0. tx_abort_n is always 1.
- R2: A command start sends CMD_WORDS words in this order: cmd_frame[31:0] first, then each higher 32-bit slice in turn. tx_eof_n is low only with the last of these words.
- R3: Every data frame begins with the header word 0x00000046, which carries tx_eof_n high.
- R4: A data start of N dwords is sent as ceil(N/MAX_PAY) frames. Every frame except the last carries exactly MAX_PAY payload dwords, and the last carries the remainder. tx_eof_n is low on the final payload dword of each frame.
- R5: The payload dwords sent equal the N dwords read from the FIFO, in the same order, with none lost or duplicated.
- R6: fifo_rd_en is asserted only while fifo_empty is 0, and at most N reads occur for a data start of N.
- R7: While tx_valid_n is 0 and tx_dst_rdy_n is 1, tx_data and tx_eof_n hold their values and the word stays valid.
- R8: A command or data start is ignored while busy is 1. A data start with data_len 0 is ignored. In both cases no extra word appears on the output.
- R9: If cmd_go and data_go are asserted in the same idle cycle, only the command frame is sent.
- R10: busy rises in the cycle after an accepted start. It stays 1 until the link accepts the last word, and it is 0 in the cycle after that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_go | input | 1 | Start a command frame (one-cycle pulse) |
| cmd_frame | input | CMD_WORDS*32 | Command-frame words; word 0 is in the low bits |
| data_go | input | 1 | Start a data stream (one-cycle pulse) |
| data_len | input | LEN_W | Payload dword count for the data stream |
| busy | output | 1 | High while a frame sequence is in progress |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| fifo_rd_en | output | 1 | Transmit FIFO read strobe |
| fifo_rd_data | input | 32 | FIFO data, valid one clock after the strobe |
| tx_data | output | 32 | Transmit word |
| tx_valid_n | output | 1 | Transmit word valid, active low |
| tx_eof_n | output | 1 | Last word of frame, active low |
| tx_abort_n | output | 1 | Transmit abort, held at 1 |
| tx_dst_rdy_n | input | 1 | Link ready to accept, active low |

## Verification
The bench aims at the frame boundaries of the data path:
- Lengths of 1, exactly MAX_PAY, MAX_PAY+1 and a multiple-frame value that is not a whole multiple of MAX_PAY. A wrong segment counter shows up as a header placed one dword off or an end-of-frame on the wrong word.
- Random link stalls and random FIFO-empty gaps. These expose a missing skid register, which drops or repeats the dword returned during a stall, and a read strobe that ignores the empty flag.
- Starts issued while busy, a zero-length start, and simultaneous command and data starts. A design that honoured any of these would put extra words on the link, and the exact expected stream would catch them.

// File: rtl/txpk_pkg.sv
package txpk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_HDR,
        ST_PAY,
        ST_FLUSH
    } txpk_state_t;

    localparam logic [7:0] DATA_FRAME_TYPE = 8'h46;

endpackage

// File: rtl/txpk_seg.sv
module txpk_seg #(
    parameter int LEN_W   = 24,
    parameter int MAX_PAY = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             frame_start,
    input  logic             rd_issue,
    input  logic             pay_load,
    output logic             tot_nz,
    output logic             frm_rd_nz,
    output logic             frm_ld_last
);
    localparam int FRM_W = $clog2(MAX_PAY + 1);

    logic [LEN_W-1:0] tot_rem;
    logic [FRM_W-1:0] frm_rd;
    logic [FRM_W-1:0] frm_ld;
    logic [FRM_W-1:0] frm_size;

    always_comb begin
        if (tot_rem > LEN_W'(MAX_PAY)) frm_size = FRM_W'(MAX_PAY);
        else                           frm_size = FRM_W'(tot_rem);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_rem <= '0;
            frm_rd  <= '0;
            frm_ld  <= '0;
        end else begin
            if (start)         tot_rem <= len;
            else if (rd_issue) tot_rem <= tot_rem - LEN_W'(1);

            if (frame_start)   frm_rd <= frm_size;
            else if (rd_issue) frm_rd <= frm_rd - FRM_W'(1);

            if (frame_start)   frm_ld <= frm_size;
            else if (pay_load) frm_ld <= frm_ld - FRM_W'(1);
        end
    end

    assign tot_nz      = (tot_rem != '0);
    assign frm_rd_nz   = (frm_rd != '0);
    assign frm_ld_last = (frm_ld == FRM_W'(1));

    // R6
    tot_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> tot_rem != '0);
    // R4
    frm_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_load |-> frm_ld != '0);
    // R4
    frm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> frm_rd <= frm_ld);

endmodule

// File: rtl/txpk_skid.sv
module txpk_skid #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_dat,
    input  logic          take,
    output logic          head_vld,
    output logic [DW-1:0] head_dat,
    output logic          skid_vld
);
    logic [DW-1:0] skid_dat;

    assign head_vld = skid_vld | in_vld;
    assign head_dat = skid_vld ? skid_dat : in_dat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skid_vld <= 1'b0;
            skid_dat <= '0;
        end else if (skid_vld) begin
            if (take) begin
                skid_vld <= in_vld;
                skid_dat <= in_dat;
            end
        end else if (in_vld && !take) begin
            skid_vld <= 1'b1;
            skid_dat <= in_dat;
        end
    end

    // R7
    skid_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skid_vld && in_vld) |-> take);
    // R5
    take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> head_vld);

endmodule

// File: rtl/txpk_top.sv
module txpk_top
    import txpk_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CMD_WORDS = 5,
    parameter int MAX_PAY   = 2048,
    parameter int LEN_W     = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_go,
    input  logic [CMD_WORDS*DW-1:0] cmd_frame,
    input  logic                  data_go,
    input  logic [LEN_W-1:0]      data_len,
    output logic                  busy,
    input  logic                  fifo_empty,
    output logic                  fifo_rd_en,
    input  logic [DW-1:0]         fifo_rd_data,
    output logic [DW-1:0]         tx_data,
    output logic                  tx_valid_n,
    output logic                  tx_eof_n,
    output logic                  tx_abort_n,
    input  logic                  tx_dst_rdy_n
);
    localparam int IDX_W = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CMD_WORDS - 1);
    localparam logic [DW-1:0] HDR_WORD = {{(DW-8){1'b0}}, DATA_FRAME_TYPE};

    txpk_state_t state, nxt;
    logic [IDX_W-1:0] idx;
    logic          out_vld, out_eof;
    logic [DW-1:0] out_dat;
    logic          rd_q;
    logic          pop, load_ok, room, rd_issue, take;
    logic [1:0]    occ;
    logic          head_vld, skid_vld;
    logic [DW-1:0] head_dat;
    logic          tot_nz, frm_rd_nz, frm_ld_last;
    logic          data_start, frame_start;

    assign pop     = out_vld & ~tx_dst_rdy_n;
    assign load_ok = ~out_vld | pop;
    assign occ     = 2'(out_vld) + 2'(skid_vld) + 2'(rd_q);
    assign room    = (occ - 2'(pop)) < 2'd2;

    assign rd_issue    = (state == ST_PAY) & frm_rd_nz & ~fifo_empty & room;
    assign take        = (state == ST_PAY) & load_ok & head_vld;
    assign data_start  = (state == ST_IDLE) & ~cmd_go & data_go & (data_len != '0);
    assign frame_start = (state == ST_HDR) & load_ok;

    txpk_seg #(.LEN_W(LEN_W), .MAX_PAY(MAX_PAY)) i_seg (
        .clk(clk), .rst_n(rst_n), .start(data_start), .len(data_len),
        .frame_start(frame_start), .rd_issue(rd_issue), .pay_load(take),
        .tot_nz(tot_nz), .frm_rd_nz(frm_rd_nz), .frm_ld_last(frm_ld_last)
    );

    txpk_skid #(.DW(DW)) i_skid (
        .clk(clk), .rst_n(rst_n), .in_vld(rd_q), .in_dat(fifo_rd_data),
        .take(take), .head_vld(head_vld), .head_dat(head_dat),
        .skid_vld(skid_vld)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_go)          nxt = ST_CMD;
                else if (data_start) nxt = ST_HDR;
            end
            ST_CMD:   if (load_ok && idx == IDX_LAST) nxt = ST_FLUSH;
            ST_HDR:   if (load_ok) nxt = ST_PAY;
            ST_PAY:   if (take && frm_ld_last) nxt = tot_nz ? ST_HDR : ST_FLUSH;
            ST_FLUSH: if (pop) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            rd_q  <= 1'b0;
        end else begin
            state <= nxt;
            rd_q  <= rd_issue;
            if (state == ST_IDLE)             idx <= '0;
            else if (state == ST_CMD && load_ok) idx <= idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_eof <= 1'b0;
            out_dat <= '0;
        end else begin
            unique case (state)
                ST_CMD: begin
                    if (load_ok) begin
                        out_vld <= 1'b1;
                        out_dat <= cmd_frame[idx*DW +: DW];
                        out_eof <= (idx == IDX_LAST);
                    end
                end
                ST_HDR: begin
                    if (load_ok) begin
                        out_vld <= 1'b1;
                        out_dat <= HDR_WORD;
                        out_eof <= 1'b0;
                    end
                end
                ST_PAY: begin
                    if (take) begin
                        out_vld <= 1'b1;
                        out_dat <= head_dat;
                        out_eof <= frm_ld_last;
                    end else if (pop) begin
                        out_vld <= 1'b0;
                    end
                end
                default: begin
                    if (pop) out_vld <= 1'b0;
                end
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign fifo_rd_en = rd_issue;
    assign tx_data    = out_dat;
    assign tx_valid_n = ~out_vld;
    assign tx_eof_n   = ~(out_vld & out_eof);
    assign tx_abort_n = 1'b1;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid_n && tx_dst_rdy_n) |=> (!tx_valid_n && $stable(tx_data) && $stable(tx_eof_n)));
    // R6
    rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_valid_n && !fifo_rd_en));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_FLUSH) |=> busy);

endmodule

// File: tb/test_txpk_top.sv
module test_txpk_top;
    localparam int DW = 32;
    localparam int CW = 5;
    localparam int MP = 2048;
    localparam int LW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_go = 1'b0;
    logic [CW*DW-1:0] cmd_frame = '0;
    logic data_go = 1'b0;
    logic [LW-1:0] data_len = '0;
    logic busy;
    logic fifo_empty = 1'b1;
    logic fifo_rd_en;
    logic [DW-1:0] fifo_rd_data = '0;
    logic [DW-1:0] tx_data;
    logic tx_valid_n, tx_eof_n, tx_abort_n;
    logic tx_dst_rdy_n = 1'b1;

    always #5 clk = ~clk;

    txpk_top #(.DW(DW), .CMD_WORDS(CW), .MAX_PAY(MP), .LEN_W(LW)) i_txpk_top (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_frame(cmd_frame),
        .data_go(data_go), .data_len(data_len), .busy(busy),
        .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
        .tx_data(tx_data), .tx_valid_n(tx_valid_n), .tx_eof_n(tx_eof_n),
        .tx_abort_n(tx_abort_n), .tx_dst_rdy_n(tx_dst_rdy_n)
    );

    logic [DW-1:0] fq[$];
    logic [DW-1:0] exp_dat[$];
    logic          exp_eof[$];
    string         exp_req[$];

    int tests_a = 0, fails_a = 0;
    int tests_m = 0, fails_m = 0;
    int tests_f = 0, fails_f = 0;
    int stall_pct = 0, empty_pct = 0;
    logic prev_stall = 1'b0;
    logic [DW-1:0] prev_dat = '0;
    logic prev_eof = 1'b1;
    logic done = 1'b0;

    function automatic int min_i(int a, int b);
        return (a < b) ? a : b;
    endfunction

    // FIFO model: data one clock after the strobe (R6 checked here)
    always @(posedge clk) begin
        if (rst_n && fifo_rd_en) begin
            tests_f++;
            if (fifo_empty || fq.size() == 0) begin
                fails_f++;
                $display("FAIL R6 read while empty: rd_en=%0b empty=%0b exp rd_en=0", fifo_rd_en, fifo_empty);
            end else begin
                fifo_rd_data <= fq.pop_front();
            end
        end
    end

    // Link model and output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                // R7 held word under stall
                tests_m++;
                if (tx_valid_n || tx_data != prev_dat || tx_eof_n != prev_eof) begin
                    fails_m++;
                    $display("FAIL R7 stall hold: data=%h eof_n=%0b exp data=%h eof_n=%0b",
                             tx_data, tx_eof_n, prev_dat, prev_eof);
                end
            end
            tx_dst_rdy_n = (($urandom % 100) < stall_pct);
            fifo_empty   = (fq.size() == 0) || (($urandom % 100) < empty_pct);
            prev_stall   = !tx_valid_n && tx_dst_rdy_n;
            prev_dat     = tx_data;
            prev_eof     = tx_eof_n;
            if (!tx_valid_n && !tx_dst_rdy_n) begin
                tests_m++;
                if (exp_dat.size() == 0) begin
                    fails_m++;
                    $display("FAIL R8 unexpected word: data=%h exp none", tx_data);
                end else begin
                    logic [DW-1:0] ed;
                    logic ee;
                    string er;
                    ed = exp_dat.pop_front();
                    ee = exp_eof.pop_front();
                    er = exp_req.pop_front();
                    if (tx_data != ed || (tx_eof_n == 1'b0) != ee) begin
                        fails_m++;
                        $display("FAIL %s word: data=%h eof=%0b exp data=%h eof=%0b",
                                 er, tx_data, !tx_eof_n, ed, ee);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        tests_a++;
        if (!ok) begin
            fails_a++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report(input int extra);
        $display("[TB] %0d tests run, %0d failed", tests_a + tests_m + tests_f + extra,
                 fails_a + fails_m + fails_f + extra);
    endtask

    task automatic build_cmd();
        for (int i = 0; i < CW; i++) begin
            cmd_frame[i*DW +: DW] = $urandom;
            exp_dat.push_back(cmd_frame[i*DW +: DW]);
            exp_eof.push_back(i == CW - 1);
            exp_req.push_back("R2");
        end
    endtask

    task automatic build_data(input int len);
        int rem = len;
        while (rem > 0) begin
            int n = min_i(rem, MP);
            exp_dat.push_back(32'h0000_0046); // R3 header
            exp_eof.push_back(1'b0);
            exp_req.push_back("R3");
            for (int i = 0; i < n; i++) begin
                logic [DW-1:0] w = $urandom;
                fq.push_back(w);
                exp_dat.push_back(w);
                exp_eof.push_back(i == n - 1);
                exp_req.push_back((i == n - 1) ? "R4" : "R5");
            end
            rem -= n;
        end
    endtask

    task automatic wait_idle(input string req);
        int cyc = 0;
        while (busy && cyc < 50000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!busy, req, "busy stuck", int'(busy), 0);
        @(negedge clk);
        chk(exp_dat.size() == 0, req, "words left", exp_dat.size(), 0);
        chk(fq.size() == 0, "R5", "fifo dwords unread", fq.size(), 0);
    endtask

    task automatic run_cmd();
        build_cmd();
        cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        chk(busy, "R10", "busy after cmd start", int'(busy), 1);
        wait_idle("R2");
    endtask

    task automatic run_data(input int len, input bit poke);
        build_data(len);
        data_len = LW'(len);
        data_go = 1'b1;
        @(negedge clk);
        data_go = 1'b0;
        chk(busy, "R10", "busy after data start", int'(busy), 1);
        if (poke) begin
            // R8 starts while busy must be ignored
            repeat (3) @(negedge clk);
            data_go = 1'b1;
            cmd_go = 1'b1;
            @(negedge clk);
            data_go = 1'b0;
            cmd_go = 1'b0;
        end
        wait_idle("R4");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy, "R1", "busy", int'(busy), 0);
        chk(tx_valid_n, "R1", "tx_valid_n", int'(tx_valid_n), 1);
        chk(tx_eof_n, "R1", "tx_eof_n", int'(tx_eof_n), 1);
        chk(!fifo_rd_en, "R1", "fifo_rd_en", int'(fifo_rd_en), 0);
        chk(tx_abort_n, "R1", "tx_abort_n", int'(tx_abort_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1", "busy after release", int'(busy), 0);

        run_cmd();
        run_data(1, 1'b0);
        run_data(MP, 1'b0);
        run_data(MP + 1, 1'b0);
        stall_pct = 30; empty_pct = 20;
        run_cmd();
        run_data(5000, 1'b1);
        run_data(1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            stall_pct = $urandom % 60;
            empty_pct = $urandom % 50;
            run_data(1 + ($urandom % 3000), k[0]);
        end

        // R8 zero-length start ignored
        data_len = '0;
        data_go = 1'b1;
        @(negedge clk);
        data_go = 1'b0;
        chk(!busy, "R8", "busy on zero length", int'(busy), 0);
        repeat (5) @(negedge clk);
        chk(!busy, "R8", "busy later on zero length", int'(busy), 0);

        // R9 simultaneous starts: command only
        stall_pct = 20; empty_pct = 0;
        build_cmd();
        data_len = LW'(7);
        cmd_go = 1'b1;
        data_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        data_go = 1'b0;
        chk(busy, "R9", "busy after dual start", int'(busy), 1);
        wait_idle("R9");
        repeat (10) @(negedge clk);
        chk(!busy && exp_dat.size() == 0, "R9", "data stream after dual start", int'(busy), 0);

        done = 1'b1;
        report(0);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired: busy=%0b expected run to end", busy);
            report(1);
            $finish;
        end
    end

endmodule